// File: doc/BRIEF.md
# Sleep and Watchdog Status Controller

This block sits beside a small microcontroller core. It owns the watchdog timer and the two status flags that tell software why the core is running: the time-out flag (`to_bit`) and the power-down flag (`pd_bit`). The watchdog is an 8-bit counter behind a 7-bit prescaler. The prescaler division is selectable in powers of two, from every cycle up to one step per 128 cycles. When the counter rolls over, the block emits a one-cycle expiry pulse.

The core pulses `sleep_req` when it executes its sleep instruction. On that edge the block does four things:
- it clears the watchdog counter and the prescaler;
- it sets `to_bit`;
- it clears `pd_bit`;
- it drops `osc_run`, which halts the core clock.

Two events bring the core back:
- A wake event from outside (interrupt logic, already synchronised and past any start-up delay) restarts the oscillator. `pd_bit` stays low, so software can see that it came back from sleep.
- A watchdog expiry also wakes the core, and it clears `to_bit` as well.

If the watchdog expires while the core is awake, the block raises a reset request and clears `to_bit`. A clear-watchdog strobe restarts the timer and sets both flags. Power-on reset also sets both flags. From the pair of flags, software can therefore tell apart a power-up, a watchdog reset, a watchdog wake-up and an event wake-up.

Top module: `sleep_wdt_ctrl`

## Requirements
- R1: After power-on reset, `to_bit`=1, `pd_bit`=1, `osc_run`=1, and `wdt_timeout` and `wdt_reset_req` are 0.
- R2: A `sleep_req` sampled at a clock edge while awake gives `to_bit`=1, `pd_bit`=0 and `osc_run`=0 from that edge on.
- R3: A `sleep_req` accepted while awake clears the watchdog counter and prescaler. The next expiry pulse therefore appears exactly 256·2^`pre_sel` cycles after that edge.
- R4: A `wdt_clr` accepted while awake, without `sleep_req`, sets `to_bit`=1 and `pd_bit`=1. It also clears the counter and prescaler, so the next expiry comes 256·2^`pre_sel` cycles later.
- R5: `pre_sel` = s (0..7) advances the counter once every 2^s cycles. `wdt_timeout` is high for exactly one cycle per rollover.
- R6: An expiry while awake drives `wdt_reset_req` high in the same cycle as `wdt_timeout`. From the next edge, `to_bit`=0 and `pd_bit` is unchanged.
- R7: An expiry while asleep does not request a reset. From the next edge, `osc_run`=1 and `to_bit`=0, while `pd_bit` stays 0.
- R8: `wake_evt` while asleep sets `osc_run`=1 at the next edge and leaves `to_bit` and `pd_bit` unchanged.
- R9: While asleep, `sleep_req` and `wdt_clr` have no effect: the flags hold and the pending expiry keeps its schedule. `wake_evt` while awake has no effect.
- R10: An expiry pulse takes priority over `sleep_req` or `wdt_clr` in the same cycle. The strobe is dropped entirely: no sleep, no flag set, no watchdog clear.
- R11: With `wdt_en`=0 the counter and prescaler are held at zero and no expiry occurs. Counting restarts from zero when the enable returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the watchdog and status logic |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wdt_en | input | 1 | Watchdog enable configuration bit |
| pre_sel | input | 3 | Prescaler select, division 2^pre_sel |
| sleep_req | input | 1 | One-cycle strobe from the sleep instruction |
| wdt_clr | input | 1 | One-cycle clear-watchdog strobe |
| wake_evt | input | 1 | Wake-up event from interrupt sources |
| to_bit | output | 1 | Time-out status flag (0 after a watchdog expiry) |
| pd_bit | output | 1 | Power-down status flag (0 after sleep) |
| osc_run | output | 1 | Oscillator run enable (0 while asleep) |
| wdt_timeout | output | 1 | One-cycle watchdog expiry pulse |
| wdt_reset_req | output | 1 | Reset request, expiry while awake |

## Verification
The hardest situation to reach is a strobe that lands in the very cycle the expiry pulse is high (R10). Random strobes almost never hit that single cycle. The stimulus therefore waits, at a falling edge, until the expiry pulse is visible, and only then raises `sleep_req` or `wdt_clr`. A second case needs an exact count: a clear strobe given while asleep must leave the expiry schedule alone. The bench checks this by measuring the sleep-to-expiry distance against 256·2^`pre_sel` with that strobe injected part-way through.

// File: rtl/swd_pkg.sv
package swd_pkg;

    // Power status flags plus the sleep state of the core
    typedef struct packed {
        logic to;
        logic pd;
        logic asleep;
    } pwr_stat_t;

    localparam pwr_stat_t PWR_STAT_RESET = '{to: 1'b1, pd: 1'b1, asleep: 1'b0};

endpackage

// File: rtl/swd_prescaler.sv
module swd_prescaler #(
    parameter int PRE_W = 7,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_state_t;

    pre_state_t       st_d, st_q;
    logic [PRE_W-1:0] mask;

    // mask bit i is set when i < sel: the tick fires when the low sel bits are all ones
    for (genvar i = 0; i < PRE_W; i++) begin : g_mask
        assign mask[i] = (int'(sel) > i);
    end

    assign tick = run && ((st_q.cnt & mask) == mask);

    always_comb begin
        st_d = st_q;
        if (clr || !run) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/swd_counter.sv
module swd_counter #(
    parameter int CNT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    input  logic tick,
    output logic expire
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pulse;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (clr || !run) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt   = st_q.cnt + 1'b1;
            st_d.pulse = (st_q.cnt == CNT_MAX);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign expire = st_q.pulse;

endmodule

// File: rtl/swd_status.sv
module swd_status
    import swd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic sleep_req,
    input  logic wdt_clr,
    input  logic wake_evt,
    output logic wd_clear,
    output logic to_bit,
    output logic pd_bit,
    output logic osc_run,
    output logic reset_req
);

    pwr_stat_t st_d, st_q;
    logic      awake;

    assign awake = !st_q.asleep;

    // Strobes count only while awake and only when no expiry is competing
    assign wd_clear = awake && !expire && (sleep_req || wdt_clr);

    always_comb begin
        st_d = st_q;
        if (expire) begin
            st_d.to     = 1'b0;
            st_d.asleep = 1'b0;
        end else if (awake && sleep_req) begin
            st_d.to     = 1'b1;
            st_d.pd     = 1'b0;
            st_d.asleep = 1'b1;
        end else if (awake && wdt_clr) begin
            st_d.to = 1'b1;
            st_d.pd = 1'b1;
        end else if (st_q.asleep && wake_evt) begin
            st_d.asleep = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= PWR_STAT_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign to_bit    = st_q.to;
    assign pd_bit    = st_q.pd;
    assign osc_run   = awake;
    assign reset_req = expire && awake;

endmodule

// File: rtl/sleep_wdt_ctrl.sv
module sleep_wdt_ctrl #(
    parameter int CNT_W = 8,
    parameter int PRE_W = 7,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wdt_en,
    input  logic [SEL_W-1:0] pre_sel,
    input  logic             sleep_req,
    input  logic             wdt_clr,
    input  logic             wake_evt,
    output logic             to_bit,
    output logic             pd_bit,
    output logic             osc_run,
    output logic             wdt_timeout,
    output logic             wdt_reset_req
);

    logic wd_clear;
    logic pre_tick;
    logic expire;

    swd_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (wdt_en),
        .clr   (wd_clear),
        .sel   (pre_sel),
        .tick  (pre_tick)
    );

    swd_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (wdt_en),
        .clr    (wd_clear),
        .tick   (pre_tick),
        .expire (expire)
    );

    swd_status u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .expire    (expire),
        .sleep_req (sleep_req),
        .wdt_clr   (wdt_clr),
        .wake_evt  (wake_evt),
        .wd_clear  (wd_clear),
        .to_bit    (to_bit),
        .pd_bit    (pd_bit),
        .osc_run   (osc_run),
        .reset_req (wdt_reset_req)
    );

    assign wdt_timeout = expire;

endmodule

// File: rtl/sleep_wdt_ctrl_chk.sv
module sleep_wdt_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic wdt_en,
    input logic sleep_req,
    input logic wdt_clr,
    input logic wake_evt,
    input logic to_bit,
    input logic pd_bit,
    input logic osc_run,
    input logic wdt_timeout,
    input logic wdt_reset_req
);

    // R2
    sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        osc_run && sleep_req && !wdt_timeout |=> !osc_run && to_bit && !pd_bit);

    // R4
    clr_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        osc_run && wdt_clr && !sleep_req && !wdt_timeout |=> osc_run && to_bit && pd_bit);

    // R5
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_timeout |=> !wdt_timeout);

    // R6
    awake_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_timeout && osc_run |-> wdt_reset_req);

    // R6
    awake_to_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_timeout && osc_run |=> !to_bit && osc_run && $stable(pd_bit));

    // R7
    wdt_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_timeout && !osc_run |=> osc_run && !to_bit && !pd_bit);

    // R7
    no_rst_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_run |-> !wdt_reset_req);

    // R8
    evt_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_run && wake_evt && !wdt_timeout |=> osc_run && !pd_bit && $stable(to_bit));

    // R9
    asleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_run && !wake_evt && !wdt_timeout |=> !osc_run && $stable(to_bit) && $stable(pd_bit));

    // R10
    prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_timeout && osc_run && (sleep_req || wdt_clr) |=> osc_run && !to_bit);

    // R11
    disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wdt_en |=> !wdt_timeout);

endmodule

bind sleep_wdt_ctrl sleep_wdt_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wdt_en        (wdt_en),
    .sleep_req     (sleep_req),
    .wdt_clr       (wdt_clr),
    .wake_evt      (wake_evt),
    .to_bit        (to_bit),
    .pd_bit        (pd_bit),
    .osc_run       (osc_run),
    .wdt_timeout   (wdt_timeout),
    .wdt_reset_req (wdt_reset_req)
);

// File: tb/sleep_wdt_ctrl_test.sv
`timescale 1ns/100ps
module sleep_wdt_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wdt_en = 1'b1;
    logic [2:0] pre_sel = 3'd0;
    logic       sleep_req = 1'b0;
    logic       wdt_clr = 1'b0;
    logic       wake_evt = 1'b0;
    logic       to_bit, pd_bit, osc_run, wdt_timeout, wdt_reset_req;

    int  n_checks = 0;
    int  n_fails = 0;
    bit  finished = 1'b0;

    // reference state
    logic [6:0] m_pre;
    logic [7:0] m_cnt;
    logic       m_tout, m_to, m_pd, m_sleep;

    always #2.5 clk = ~clk;

    sleep_wdt_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wdt_en(wdt_en), .pre_sel(pre_sel),
        .sleep_req(sleep_req), .wdt_clr(wdt_clr), .wake_evt(wake_evt),
        .to_bit(to_bit), .pd_bit(pd_bit), .osc_run(osc_run),
        .wdt_timeout(wdt_timeout), .wdt_reset_req(wdt_reset_req)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic chk_int(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [6:0] sel_mask(input logic [2:0] s);
        return 7'((8'd1 << s) - 8'd1);
    endfunction

    // expected next state from the requirements, using inputs held at this edge
    task automatic model_edge();
        logic       clear, tick;
        logic [6:0] n_pre;
        logic [7:0] n_cnt;
        logic       n_tout, n_to, n_pd, n_sleep;
        clear   = !m_sleep && !m_tout && (sleep_req || wdt_clr);   // R10 R9
        n_to    = m_to;
        n_pd    = m_pd;
        n_sleep = m_sleep;
        if (m_tout) begin                 // R6 R7
            n_to    = 1'b0;
            n_sleep = 1'b0;
        end else if (!m_sleep && sleep_req) begin   // R2
            n_to = 1'b1; n_pd = 1'b0; n_sleep = 1'b1;
        end else if (!m_sleep && wdt_clr) begin     // R4
            n_to = 1'b1; n_pd = 1'b1;
        end else if (m_sleep && wake_evt) begin     // R8
            n_sleep = 1'b0;
        end
        tick   = wdt_en && ((m_pre & sel_mask(pre_sel)) == sel_mask(pre_sel));  // R5
        n_tout = 1'b0;
        if (clear || !wdt_en) begin       // R3 R11
            n_pre = '0;
            n_cnt = '0;
        end else begin
            n_pre = m_pre + 7'd1;
            n_cnt = m_cnt;
            if (tick) begin
                n_tout = (m_cnt == 8'hFF);
                n_cnt  = m_cnt + 8'd1;
            end
        end
        m_pre = n_pre; m_cnt = n_cnt; m_tout = n_tout;
        m_to = n_to; m_pd = n_pd; m_sleep = n_sleep;
    endtask

    task automatic compare_all();
        chk("R6", "to_bit", to_bit, m_to);
        chk("R2", "pd_bit", pd_bit, m_pd);
        chk("R8", "osc_run", osc_run, !m_sleep);
        chk("R5", "wdt_timeout", wdt_timeout, m_tout);
        chk("R6", "wdt_reset_req", wdt_reset_req, m_tout && !m_sleep);
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic pulse_sleep();
        sleep_req = 1'b1; step(); sleep_req = 1'b0;
    endtask

    task automatic pulse_clr();
        wdt_clr = 1'b1; step(); wdt_clr = 1'b0;
    endtask

    // steps until the expiry pulse is visible, returns number of steps
    task automatic wait_expiry(output int n);
        n = 0;
        while (!wdt_timeout && n < 40000) begin
            step();
            n++;
        end
    endtask

    initial begin
        int n;
        int s;
        int dummy;
        dummy = $urandom(32'd20240611);
        m_pre = '0; m_cnt = '0; m_tout = 1'b0;
        m_to = 1'b1; m_pd = 1'b1; m_sleep = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1", "to_bit", to_bit, 1'b1);
        chk("R1", "pd_bit", pd_bit, 1'b1);
        chk("R1", "osc_run", osc_run, 1'b1);
        chk("R1", "wdt_timeout", wdt_timeout, 1'b0);
        chk("R1", "wdt_reset_req", wdt_reset_req, 1'b0);

        // R3 R5: period from sleep for several ratios, then watchdog wake (R7)
        for (int k = 0; k < 5; k++) begin
            s = (k == 4) ? 7 : k + 1;
            pre_sel = 3'(s);
            pulse_sleep();
            chk("R2", "osc_run after sleep", osc_run, 1'b0);
            chk("R2", "pd_bit after sleep", pd_bit, 1'b0);
            chk("R2", "to_bit after sleep", to_bit, 1'b1);
            wait_expiry(n);
            chk_int("R3", "sleep-to-expiry cycles", n, 256 << s);
            chk("R7", "no reset request asleep", wdt_reset_req, 1'b0);
            step();
            chk("R5", "pulse one cycle", wdt_timeout, 1'b0);
            chk("R7", "osc_run after wdt wake", osc_run, 1'b1);
            chk("R7", "to_bit after wdt wake", to_bit, 1'b0);
            chk("R7", "pd_bit after wdt wake", pd_bit, 1'b0);
        end

        // R4 R6: clear then expiry while awake
        pre_sel = 3'd0;
        pulse_clr();
        chk("R4", "to_bit after clr", to_bit, 1'b1);
        chk("R4", "pd_bit after clr", pd_bit, 1'b1);
        wait_expiry(n);
        chk_int("R4", "clr-to-expiry cycles", n, 256);
        chk("R6", "reset request awake", wdt_reset_req, 1'b1);
        step();
        chk("R6", "to_bit after awake expiry", to_bit, 1'b0);
        chk("R6", "pd_bit held", pd_bit, 1'b1);

        // R10: sleep strobe coincident with expiry is dropped
        wait_expiry(n);
        sleep_req = 1'b1; step(); sleep_req = 1'b0;
        chk("R10", "osc_run stays", osc_run, 1'b1);
        chk("R10", "pd_bit stays", pd_bit, 1'b1);
        chk("R10", "to_bit cleared", to_bit, 1'b0);
        // clear strobe coincident with expiry: watchdog not cleared either
        wait_expiry(n);
        chk_int("R10", "expiry spacing", n, 255);
        wdt_clr = 1'b1; step(); wdt_clr = 1'b0;
        chk("R10", "to_bit not set", to_bit, 1'b0);
        wait_expiry(n);
        chk_int("R10", "schedule after dropped clr", n, 255);

        // R9: strobes while asleep ignored, schedule kept
        step();
        pulse_sleep();
        repeat (100) step();
        pulse_clr();
        chk("R9", "osc_run after clr asleep", osc_run, 1'b0);
        chk("R9", "to_bit after clr asleep", to_bit, 1'b1);
        chk("R9", "pd_bit after clr asleep", pd_bit, 1'b0);
        pulse_sleep();
        wait_expiry(n);
        chk_int("R9", "expiry kept schedule", n, 256 - 102);
        step();

        // R8: event wake, then wake while awake ignored (R9)
        pulse_clr();
        pulse_sleep();
        repeat (10) step();
        wake_evt = 1'b1; step(); wake_evt = 1'b0;
        chk("R8", "osc_run after event", osc_run, 1'b1);
        chk("R8", "pd_bit stays low", pd_bit, 1'b0);
        chk("R8", "to_bit unchanged", to_bit, 1'b1);
        wake_evt = 1'b1; step(); wake_evt = 1'b0;
        chk("R9", "wake while awake", osc_run, 1'b1);
        chk("R9", "pd after wake awake", pd_bit, 1'b0);

        // R11: disabled watchdog never expires, restarts from zero
        wdt_en = 1'b0;
        n = 0;
        for (int i = 0; i < 3000; i++) begin
            step();
            if (wdt_timeout) n++;
        end
        chk_int("R11", "expiries while disabled", n, 0);
        wdt_en = 1'b1;
        wait_expiry(n);
        chk_int("R11", "restart period", n, 256);

        // random mix against the reference model
        for (int i = 0; i < 60000; i++) begin
            int r;
            r = int'($urandom_range(0, 999));
            sleep_req = (r < 8);
            wdt_clr   = (r >= 8 && r < 14);
            wake_evt  = (r >= 14 && r < 24);
            if (r >= 995) wdt_en = ~wdt_en;
            if (r >= 990 && r < 995) pre_sel = 3'($urandom_range(0, 2));
            if (!wdt_en && r > 900) wdt_en = 1'b1;
            step();
        end
        sleep_req = 1'b0; wdt_clr = 1'b0; wake_evt = 1'b0;

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(5.0 * 190000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired, run hung");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
            $finish;
        end
    end

endmodule